// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 interrupt lines and presents them to a processor as one request wire. Software reaches it through a small word-wide register bus with an address, a write strobe, write data and read data. Each input line has its own status bit. Whether that bit records a rising edge or follows a level is fixed per input by a kind-mask parameter. An enable mask selects which status bits count as pending. A two-bit master control gates the request. A vector register names the lowest-numbered pending input, so an interrupt handler can dispatch without scanning.

Enable bits can be changed atomically through a set-alias and a clear-alias address, which avoids read-modify-write sequences in the handler. Status bits are cleared by writing ones to an acknowledge address. The request output comes from a two-state machine, `REQ_IDLE` and `REQ_ACTIVE`. The machine moves from `REQ_IDLE` to `REQ_ACTIVE` when both master bits are set and at least one input is pending. It moves back from `REQ_ACTIVE` to `REQ_IDLE` when either of those conditions is lost. The output therefore follows the pending condition one clock later.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the status, enable and master registers read 0, the vector register reads 0xFFFFFFFF and `irq_o` is 0.
- R2: For an input whose kind-mask bit is 1 (edge), a rising edge sets its status bit (bit i of the word at byte offset 0x00 belongs to input i). The bit stays set after the input falls, until it is acknowledged. Acknowledging it while the input is held high clears it.
- R3: For an input whose kind-mask bit is 0 (level), the status bit is set in every cycle the input is high. An acknowledge while the input is still high leaves the bit set. An acknowledge after the input has fallen clears it.
- R4: Writing to offset 0x0C clears exactly the status bits whose data bit is 1, and writing all ones clears every status bit. A capture in the same cycle takes precedence over the clear.
- R5: Writing to offset 0x10 sets the enable bits whose data bit is 1 and leaves the other enable bits unchanged.
- R6: Writing to offset 0x14 clears the enable bits whose data bit is 1 and leaves the other enable bits unchanged.
- R7: Writing to offset 0x08 replaces the whole enable mask, which reads back at 0x08. Writing 0 there disables every input.
- R8: Offset 0x04 reads the pending mask, which is status AND enable.
- R9: Offset 0x18 reads the index of the lowest-numbered pending input, or 0xFFFFFFFF when nothing is pending.
- R10: Offset 0x1C holds the master bits (bit 0 master enable, bit 1 hardware request enable), readable back. `irq_o` is 1 one cycle after both bits are set and at least one input is pending, and it is 0 one cycle after either condition is lost.
- R11: Positions at or above the input count are absent: they read 0 in the status, enable and pending words, even after all ones are written to the enable word.
- R12: Writes to the read-only offsets 0x00, 0x04 and 0x18 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 5 | Byte address; bits 4:2 select the register |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the register at `addr_i` (combinational) |
| irq_src_i | input | NUM_IN | Interrupt input lines, synchronous to `clk_i` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The capture path is exercised with three input shapes: a one-cycle pulse, a line held high across an acknowledge, and a line lowered before the acknowledge. Together they separate edge capture from level capture, and a true clear from a bit that the still-asserted line sets again. The enable path is driven through the direct, set-alias and clear-alias writes with overlapping bit patterns, so that a plain overwrite cannot pass for a masked update. The vector and request outputs are checked with several pending bits at once, with each master-bit combination, and after the last pending bit is removed. This shows the lowest-index choice, the all-ones empty code, and the one-cycle latency of the request.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int DATA_W = 32;
    localparam int MAX_IN = 32;

    // word select taken from addr[4:2]
    typedef enum logic [2:0] {
        REG_STAT   = 3'd0,
        REG_PEND   = 3'd1,
        REG_EN     = 3'd2,
        REG_ACK    = 3'd3,
        REG_SETEN  = 3'd4,
        REG_CLREN  = 3'd5,
        REG_VEC    = 3'd6,
        REG_MASTER = 3'd7
    } reg_sel_e;

    typedef enum logic {
        REQ_IDLE   = 1'b0,
        REQ_ACTIVE = 1'b1
    } req_state_e;
endpackage

// File: rtl/irqv_capture.sv
module irqv_capture #(
    parameter int          NUM_IN    = 8,
    parameter logic [31:0] KIND_MASK = 32'h0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_IN-1:0] src_i,
    input  logic [NUM_IN-1:0] clr_i,
    output logic [NUM_IN-1:0] set_o,
    output logic [NUM_IN-1:0] status_o
);
    logic [NUM_IN-1:0] status_q;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        if (KIND_MASK[i]) begin : g_edge
            logic prev_q;
            always_ff @(posedge clk_i) begin
                if (!rst_ni) prev_q <= 1'b0;
                else         prev_q <= src_i[i];
            end
            assign set_o[i] = src_i[i] & ~prev_q;
        end else begin : g_level
            assign set_o[i] = src_i[i];
        end
    end

    // capture wins over a clear arriving in the same cycle
    always_ff @(posedge clk_i) begin
        if (!rst_ni) status_q <= '0;
        else         status_q <= (status_q & ~clr_i) | set_o;
    end

    assign status_o = status_q;
endmodule

// File: rtl/irqv_lowest.sv
module irqv_lowest #(
    parameter int NUM_IN = 8,
    parameter int IDX_W  = 32
) (
    input  logic [NUM_IN-1:0] vec_i,
    output logic              found_o,
    output logic [IDX_W-1:0]  idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '1;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int          NUM_IN    = 8,
    parameter logic [31:0] KIND_MASK = 32'h0000_010F
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [4:0]        addr_i,
    input  logic              we_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic [NUM_IN-1:0] irq_src_i,
    output logic              irq_o
);
    localparam int SEL_LSB = 2;
    localparam int SEL_W   = 3;

    reg_sel_e          sel;
    logic [NUM_IN-1:0] wmask;
    logic [NUM_IN-1:0] ack_mask;
    logic [NUM_IN-1:0] set_vec;
    logic [NUM_IN-1:0] status_q;
    logic [NUM_IN-1:0] en_q;
    logic [1:0]        me_q;
    logic [NUM_IN-1:0] pend;
    logic              any_pend;
    logic [DATA_W-1:0] vec_idx;
    logic              gate;
    req_state_e        state_q, state_d;
    logic              unused_bits;

    assign sel      = reg_sel_e'(addr_i[SEL_LSB +: SEL_W]);
    assign wmask    = wdata_i[NUM_IN-1:0];
    assign ack_mask = (we_i && sel == REG_ACK) ? wmask : '0;
    assign unused_bits = ^{addr_i[SEL_LSB-1:0], wdata_i};

    irqv_capture #(
        .NUM_IN   (NUM_IN),
        .KIND_MASK(KIND_MASK)
    ) u_capture (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .src_i   (irq_src_i),
        .clr_i   (ack_mask),
        .set_o   (set_vec),
        .status_o(status_q)
    );

    // enable mask and its atomic aliases
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            en_q <= '0;
            me_q <= 2'b00;
        end else if (we_i) begin
            unique case (sel)
                REG_EN:     en_q <= wmask;
                REG_SETEN:  en_q <= en_q | wmask;
                REG_CLREN:  en_q <= en_q & ~wmask;
                REG_MASTER: me_q <= wdata_i[1:0];
                default:    ;
            endcase
        end
    end

    assign pend = status_q & en_q;

    irqv_lowest #(
        .NUM_IN(NUM_IN),
        .IDX_W (DATA_W)
    ) u_lowest (
        .vec_i  (pend),
        .found_o(any_pend),
        .idx_o  (vec_idx)
    );

    assign gate = me_q[0] & me_q[1];

    // request state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= REQ_IDLE;
        else         state_q <= state_d;
    end

    // next state and output
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:   if (gate && any_pend)    state_d = REQ_ACTIVE;
            REQ_ACTIVE: if (!(gate && any_pend)) state_d = REQ_IDLE;
        endcase
    end

    assign irq_o = (state_q == REQ_ACTIVE);

    // read mux
    always_comb begin
        unique case (sel)
            REG_STAT:   rdata_o = DATA_W'(status_q);
            REG_PEND:   rdata_o = DATA_W'(pend);
            REG_EN:     rdata_o = DATA_W'(en_q);
            REG_VEC:    rdata_o = vec_idx;
            REG_MASTER: rdata_o = DATA_W'(me_q);
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
    parameter int          NUM_IN    = 8,
    parameter logic [31:0] KIND_MASK = 32'h0
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              we_i,
    input logic [2:0]        sel_i,
    input logic [31:0]       wdata_i,
    input logic [NUM_IN-1:0] irq_src_i,
    input logic [NUM_IN-1:0] set_vec,
    input logic [NUM_IN-1:0] status_q,
    input logic [NUM_IN-1:0] en_q,
    input logic [1:0]        me_q,
    input logic [NUM_IN-1:0] pend,
    input logic              any_pend,
    input logic [31:0]       vec_idx,
    input logic              irq_o
);
    localparam logic [NUM_IN-1:0] LVL = ~KIND_MASK[NUM_IN-1:0];

    logic [NUM_IN-1:0] below_mask;
    assign below_mask = (NUM_IN'(1) << vec_idx[4:0]) - NUM_IN'(1);

    // R10
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(me_q == 2'b11 && (|pend)));

    // R5
    set_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && sel_i == 3'd4) |=>
        ((en_q & $past(wdata_i[NUM_IN-1:0])) == $past(wdata_i[NUM_IN-1:0])));

    // R6
    clear_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && sel_i == 3'd5) |=> ((en_q & $past(wdata_i[NUM_IN-1:0])) == '0));

    // R4
    ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && sel_i == 3'd3) |=>
        ((status_q & $past(wdata_i[NUM_IN-1:0]) & ~$past(set_vec)) == '0));

    // R3
    level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(irq_src_i & LVL)) |=>
        ((status_q & $past(irq_src_i & LVL)) == $past(irq_src_i & LVL)));

    // R9
    vector_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_pend |-> (pend[vec_idx[4:0]] && ((pend & below_mask) == '0)));

    // R9
    vector_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !any_pend |-> (vec_idx == 32'hFFFF_FFFF && pend == '0));
endmodule

bind irq_vector_ctrl irqv_checker #(
    .NUM_IN   (NUM_IN),
    .KIND_MASK(KIND_MASK)
) u_irqv_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .sel_i    (sel),
    .wdata_i  (wdata_i),
    .irq_src_i(irq_src_i),
    .set_vec  (set_vec),
    .status_q (status_q),
    .en_q     (en_q),
    .me_q     (me_q),
    .pend     (pend),
    .any_pend (any_pend),
    .vec_idx  (vec_idx),
    .irq_o    (irq_o)
);

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
    localparam int N = 8;
    localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_EN = 5'h08,
                           A_ACK = 5'h0C, A_SET = 5'h10, A_CLR = 5'h14,
                           A_VEC = 5'h18, A_MST = 5'h1C;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [4:0]   addr = '0;
    logic         we = 1'b0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [N-1:0] src = '0;
    logic         irq;
    int           n_chk = 0;
    int           n_bad = 0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl #(.NUM_IN(N), .KIND_MASK(32'h0000_010F)) u_irq_vector_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
        .rdata_o(rdata), .irq_src_i(src), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk); addr = a; #1;
        check(req, rdata, exp);
    endtask

    task automatic irq_chk(input string req, input logic exp);
        @(negedge clk); #1;
        check(req, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(negedge clk); src = src | m;
        @(negedge clk); src = src & ~m;
    endtask

    task automatic t_reset;
        rd_chk("R1 status", A_STAT, 32'h0);
        rd_chk("R1 enable", A_EN, 32'h0);
        rd_chk("R1 master", A_MST, 32'h0);
        rd_chk("R1 vector", A_VEC, 32'hFFFF_FFFF);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_edge;
        pulse(8'h04);
        rd_chk("R2 pulse held", A_STAT, 32'h04);
        @(negedge clk); src[1] = 1'b1;
        @(negedge clk);
        rd_chk("R2 captured", A_STAT, 32'h06);
        wr(A_ACK, 32'h02);
        rd_chk("R2 ack while high", A_STAT, 32'h04);
        @(negedge clk); src[1] = 1'b0;
    endtask

    task automatic t_level;
        @(negedge clk); src[5] = 1'b1;
        rd_chk("R3 level set", A_STAT, 32'h24);
        wr(A_ACK, 32'h20);
        rd_chk("R3 ack while high", A_STAT, 32'h24);
        @(negedge clk); src[5] = 1'b0;
        wr(A_ACK, 32'h20);
        rd_chk("R3 ack after low", A_STAT, 32'h04);
    endtask

    task automatic t_ack;
        pulse(8'h09);
        rd_chk("R4 three set", A_STAT, 32'h0D);
        wr(A_ACK, 32'h08);
        rd_chk("R4 one cleared", A_STAT, 32'h05);
        wr(A_ACK, 32'hFFFF_FFFF);
        rd_chk("R4 all cleared", A_STAT, 32'h0);
    endtask

    task automatic t_enable;
        wr(A_EN, 32'h0F);
        rd_chk("R7 direct", A_EN, 32'h0F);
        wr(A_SET, 32'h30);
        rd_chk("R5 set alias", A_EN, 32'h3F);
        wr(A_CLR, 32'h05);
        rd_chk("R6 clear alias", A_EN, 32'h3A);
        wr(A_EN, 32'h0);
        rd_chk("R7 zero", A_EN, 32'h0);
        wr(A_EN, 32'hFFFF_FFFF);
        rd_chk("R11 enable width", A_EN, 32'hFF);
        wr(A_EN, 32'h3A);
    endtask

    task automatic t_vector;
        pulse(8'h09);
        rd_chk("R8 pending", A_PEND, 32'h08);
        rd_chk("R9 single", A_VEC, 32'h3);
        wr(A_SET, 32'h01);
        rd_chk("R8 pending two", A_PEND, 32'h09);
        rd_chk("R9 lowest", A_VEC, 32'h0);
        wr(A_ACK, 32'h01);
        rd_chk("R9 next", A_VEC, 32'h3);
        wr(A_ACK, 32'hFFFF_FFFF);
        rd_chk("R9 empty", A_VEC, 32'hFFFF_FFFF);
        rd_chk("R8 empty", A_PEND, 32'h0);
    endtask

    task automatic t_master;
        pulse(8'h08);
        wr(A_MST, 32'h0);
        irq_chk("R10 master 00", 1'b0);
        wr(A_MST, 32'h2);
        irq_chk("R10 master 10", 1'b0);
        wr(A_MST, 32'h1);
        irq_chk("R10 master 01", 1'b0);
        wr(A_MST, 32'h3);
        irq_chk("R10 master 11", 1'b1);
        rd_chk("R10 readback", A_MST, 32'h3);
        wr(A_CLR, 32'h08);
        irq_chk("R10 drop", 1'b0);
    endtask

    task automatic t_readonly;
        wr(A_STAT, 32'h0);
        wr(A_PEND, 32'hFF);
        wr(A_VEC, 32'h0);
        rd_chk("R12 status kept", A_STAT, 32'h08);
        rd_chk("R12 enable kept", A_EN, 32'h33);
        rd_chk("R12 vector", A_VEC, 32'hFFFF_FFFF);
        wr(A_EN, 32'hFFFF_FFFF);
        rd_chk("R11 pending width", A_PEND, 32'h08);
        wr(A_ACK, 32'hFFFF_FFFF);
        rd_chk("R11 status width", A_STAT, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_edge();
        t_level();
        t_ack();
        t_enable();
        t_vector();
        t_master();
        t_readonly();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule